// File: doc/BRIEF.md
# Linear-Mask Correlation Counter Array

This block measures, by exhaustive enumeration under one fixed key, how often a set of linear approximations of a small iterated cipher hold. After a start pulse, an internal plaintext register walks through every one of the 2^n plaintext values at one per cycle. Each plaintext goes through a pipelined cipher of `ROUNDS` rounds. The last `TAPS` rounds are tapped. For every combination of input mask, output mask and tapped round, a dedicated counter records how many plaintexts give the same parity on both sides.

Each input mask is applied to the plaintext at issue time. The resulting parity bit travels alongside the cipher data, so it reaches each tapped round together with that plaintext's state. Each tap has one pipeline register for its mask comparison, so more masks do not lengthen the cipher path. When the final plaintext has reached the deepest tap's counters, a done flag rises and the counters freeze. They are then read out one per cycle through a daisy chain that runs across all of them.

Top module: `lmc_corr_array`

## Requirements
- R1: A start pulse resets the plaintext register to 0. On each following cycle it issues one plaintext and then increments by 1, so every value from 0 to 2^n-1 is issued exactly once, in ascending order.
- R2: The cipher first XORs the plaintext with round key 0. Each round r (1..ROUNDS) then applies three steps to the state. First, every 4-bit nibble passes through the substitution {6,B,0,9,E,3,C,5,8,F,2,D,1,4,A,7} (input value 0..F in order). Second, state bit i moves to bit (i*n/4) mod (n-1), with bit n-1 fixed. Third, the state is XORed with round key r. Round key r is the key rotated left by r within n bits, XORed with r. The key is captured at start.
- R3: Counter (t,a,b) counts the plaintexts p for which parity(alpha_a AND p) equals parity(beta_b AND state after round ROUNDS-TAPS+1+t). Alpha_a sits at ALPHA_MASKS[a*n +: n] and beta_b sits at BETA_MASKS[b*n +: n]. Each counter is n+1 bits wide, so it can reach 2^n without wrapping.
- R4: Counter (t,a,b) sits at chain position (t*A_MASKS+a)*B_MASKS+b. `chain_out_o` shows the highest position. Each accepted shift moves every counter one position toward the output, and position 0 loads `chain_in_i`.
- R5: `done_o` is 0 until the clock edge numbered 2^n+ROUNDS+2, taking the edge that samples start as edge 0. It is 1 from that edge on, until the next start.
- R6: A start pulse clears all counters and `done_o` and discards results still in flight. A run restarted in mid-run therefore gives the same counts as a clean run.
- R7: A shift request while `done_o` is 0 is ignored.
- R8: While `done_o` is 1, the counter values hold until a shift or a start.
- R9: After reset, `done_o` is 0 and every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a run: clears the counters, captures the key, restarts the plaintext walk |
| key_i | input | N_BITS | Cipher key, sampled with start |
| shift_i | input | 1 | Shift the counter chain by one position (accepted only while done) |
| chain_in_i | input | N_BITS+1 | Value loaded into chain position 0 on a shift |
| chain_out_o | output | N_BITS+1 | Counter at the highest chain position |
| done_o | output | 1 | All plaintext results have been counted |

## Verification
A misaligned parity delay, a wrong round key or a dropped increment does not show at the ports during a run. It shows only after `done_o` rises, as wrong values on `chain_out_o` during readout. The zero-mask pair must read exactly 2^n, so a wrapped or truncated counter shows up at that chain position. A stuck or early plaintext walk, or a start that fails to flush the pipeline, shows as `done_o` rising on the wrong cycle. That is visible at once, because the flag is compared on every clock.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  localparam int MAX_W = 64;
  typedef logic [MAX_W-1:0] word_t;

  // 4-bit substitution, a fixed bijection
  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h6;  4'h1: y = 4'hB;  4'h2: y = 4'h0;  4'h3: y = 4'h9;
      4'h4: y = 4'hE;  4'h5: y = 4'h3;  4'h6: y = 4'hC;  4'h7: y = 4'h5;
      4'h8: y = 4'h8;  4'h9: y = 4'hF;  4'hA: y = 4'h2;  4'hB: y = 4'hD;
      4'hC: y = 4'h1;  4'hD: y = 4'h4;  4'hE: y = 4'hA;  default: y = 4'h7;
    endcase
    return y;
  endfunction

  function automatic word_t sub_layer(input word_t x, input int n);
    word_t y;
    y = '0;
    for (int j = 0; j < MAX_W / 4; j++) begin
      if (4 * j < n) y[4*j +: 4] = sbox4(x[4*j +: 4]);
    end
    return y;
  endfunction

  // bit i -> (i*n/4) mod (n-1); top bit stays
  function automatic word_t perm_layer(input word_t x, input int n);
    word_t y;
    int    dst;
    y = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < n) begin
        dst = (i == n - 1) ? i : (i * (n / 4)) % (n - 1);
        y[dst[5:0]] = x[i[5:0]];
      end
    end
    return y;
  endfunction

  // key rotated left by r inside n bits, xor r
  function automatic word_t round_key(input word_t key, input int r, input int n);
    word_t y;
    int    dst;
    y = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < n) begin
        dst = (i + r) % n;
        y[dst[5:0]] = key[i[5:0]];
      end
    end
    return y ^ word_t'(r);
  endfunction

  function automatic word_t cipher_round(input word_t x, input word_t rk, input int n);
    return perm_layer(sub_layer(x, n), n) ^ rk;
  endfunction

  function automatic logic mask_parity(input word_t m, input word_t d);
    return ^(m & d);
  endfunction

endpackage

// File: rtl/lmc_pt_gen.sv
module lmc_pt_gen #(
  parameter int N_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [N_BITS-1:0] pt_o,
  output logic              issue_o,
  output logic              last_o
);
  localparam logic [N_BITS-1:0] PT_MAX = '1;

  logic              running_q;
  logic [N_BITS-1:0] pt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pt_q      <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      pt_q      <= '0;
    end else if (running_q) begin
      if (pt_q == PT_MAX) running_q <= 1'b0;
      else                pt_q      <= pt_q + 1'b1;
    end
  end

  assign pt_o    = pt_q;
  assign issue_o = running_q;
  assign last_o  = running_q && (pt_q == PT_MAX);

  // R1
  pt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !start_i && pt_q != PT_MAX) |=> (running_q && pt_q == $past(pt_q) + 1'b1));

  // R1
  pt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (running_q && pt_q == '0));

endmodule

// File: rtl/lmc_cipher_pipe.sv
module lmc_cipher_pipe
  import lmc_pkg::*;
#(
  parameter int N_BITS  = 8,
  parameter int ROUNDS  = 4,
  parameter int TAPS    = 2,
  parameter int A_MASKS = 2,
  parameter logic [A_MASKS*N_BITS-1:0] ALPHA_MASKS = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush_i,
  input  logic [N_BITS-1:0]               key_i,
  input  logic [N_BITS-1:0]               pt_i,
  input  logic                            issue_i,
  input  logic                            last_i,
  output logic [TAPS-1:0][N_BITS-1:0]     tap_data_o,
  output logic [TAPS-1:0]                 tap_vld_o,
  output logic [TAPS-1:0]                 tap_last_o,
  output logic [TAPS-1:0][A_MASKS-1:0]    tap_apar_o
);
  localparam int TAP_FIRST = ROUNDS - TAPS + 1;

  logic [ROUNDS:0][N_BITS-1:0]  st_data;
  logic [ROUNDS:0]              st_vld;
  logic [ROUNDS:0]              st_last;
  logic [ROUNDS:0][A_MASKS-1:0] st_apar;
  logic [A_MASKS-1:0]           apar_in;

  // input-mask parities, computed once at issue
  always_comb begin
    for (int a = 0; a < A_MASKS; a++) begin
      apar_in[a] = mask_parity(word_t'(ALPHA_MASKS[a*N_BITS +: N_BITS]), word_t'(pt_i));
    end
  end

  for (genvar s = 0; s <= ROUNDS; s++) begin : g_stage
    word_t nxt_w;
    if (s == 0) begin : g_head
      always_comb nxt_w = word_t'(pt_i) ^ round_key(word_t'(key_i), 0, N_BITS);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_data[s] <= '0;
          st_vld[s]  <= 1'b0;
          st_last[s] <= 1'b0;
          st_apar[s] <= '0;
        end else begin
          st_data[s] <= nxt_w[N_BITS-1:0];
          st_vld[s]  <= issue_i && !flush_i;
          st_last[s] <= last_i && !flush_i;
          st_apar[s] <= apar_in;
        end
      end
    end else begin : g_round
      always_comb nxt_w = cipher_round(word_t'(st_data[s-1]),
                                       round_key(word_t'(key_i), s, N_BITS), N_BITS);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_data[s] <= '0;
          st_vld[s]  <= 1'b0;
          st_last[s] <= 1'b0;
          st_apar[s] <= '0;
        end else begin
          st_data[s] <= nxt_w[N_BITS-1:0];
          st_vld[s]  <= st_vld[s-1] && !flush_i;
          st_last[s] <= st_last[s-1] && !flush_i;
          st_apar[s] <= st_apar[s-1];
        end
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap_out
    assign tap_data_o[t] = st_data[TAP_FIRST+t];
    assign tap_vld_o[t]  = st_vld[TAP_FIRST+t];
    assign tap_last_o[t] = st_last[TAP_FIRST+t];
    assign tap_apar_o[t] = st_apar[TAP_FIRST+t];
  end

  // R6
  flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (st_vld == '0 && st_last == '0));

  // R1
  last_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_last) <= 1);

endmodule

// File: rtl/lmc_tap_mask.sv
module lmc_tap_mask
  import lmc_pkg::*;
#(
  parameter int N_BITS  = 8,
  parameter int A_MASKS = 2,
  parameter int B_MASKS = 2,
  parameter logic [B_MASKS*N_BITS-1:0] BETA_MASKS = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic [N_BITS-1:0]            data_i,
  input  logic                         vld_i,
  input  logic                         last_i,
  input  logic [A_MASKS-1:0]           apar_i,
  output logic [A_MASKS*B_MASKS-1:0]   match_o,
  output logic                         vld_o,
  output logic                         last_o
);
  localparam int PAIRS = A_MASKS * B_MASKS;

  logic [B_MASKS-1:0] bpar;
  logic [PAIRS-1:0]   match_nxt;

  always_comb begin
    for (int b = 0; b < B_MASKS; b++) begin
      bpar[b] = mask_parity(word_t'(BETA_MASKS[b*N_BITS +: N_BITS]), word_t'(data_i));
    end
    for (int a = 0; a < A_MASKS; a++) begin
      for (int b = 0; b < B_MASKS; b++) begin
        match_nxt[a*B_MASKS+b] = (apar_i[a] == bpar[b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o <= '0;
      vld_o   <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      match_o <= match_nxt;
      vld_o   <= vld_i && !flush_i;
      last_o  <= last_i && !flush_i;
    end
  end

  // R5
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !flush_i) |=> (vld_o && last_o == $past(last_i)));

endmodule

// File: rtl/lmc_count_chain.sv
module lmc_count_chain #(
  parameter int CNT_W = 9,
  parameter int TOTAL = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         shift_i,
  input  logic [TOTAL-1:0]             inc_i,
  input  logic [CNT_W-1:0]             chain_i,
  output logic [TOTAL-1:0][CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]             chain_o
);
  logic [TOTAL-1:0][CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < TOTAL; i++) begin : g_cnt
    logic [CNT_W-1:0] shift_src;
    if (i == 0) begin : g_first
      assign shift_src = chain_i;
    end else begin : g_link
      assign shift_src = cnt_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[i] <= '0;
      else if (clr_i)     cnt_q[i] <= '0;
      else if (shift_i)   cnt_q[i] <= shift_src;
      else if (inc_i[i])  cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] != '0 && !clr_i && !shift_i) |=> (cnt_q[i] != '0));
  end

  assign cnt_o   = cnt_q;
  assign chain_o = cnt_q[TOTAL-1];

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R4
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |=> (chain_o == $past(cnt_q[TOTAL-2])));

endmodule

// File: rtl/lmc_corr_array.sv
module lmc_corr_array
  import lmc_pkg::*;
#(
  parameter int N_BITS  = 8,
  parameter int ROUNDS  = 4,
  parameter int TAPS    = 2,
  parameter int A_MASKS = 2,
  parameter int B_MASKS = 2,
  parameter logic [A_MASKS*N_BITS-1:0] ALPHA_MASKS = 16'h5A00,
  parameter logic [B_MASKS*N_BITS-1:0] BETA_MASKS  = 16'hC300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N_BITS-1:0] key_i,
  input  logic              shift_i,
  input  logic [N_BITS:0]   chain_in_i,
  output logic [N_BITS:0]   chain_out_o,
  output logic              done_o
);
  localparam int CNT_W = N_BITS + 1;
  localparam int PAIRS = A_MASKS * B_MASKS;
  localparam int TOTAL = TAPS * PAIRS;

  logic [N_BITS-1:0]             key_q;
  logic [N_BITS-1:0]             pt;
  logic                          issue;
  logic                          pt_last;
  logic [TAPS-1:0][N_BITS-1:0]   tap_data;
  logic [TAPS-1:0]               tap_pvld;
  logic [TAPS-1:0]               tap_plast;
  logic [TAPS-1:0][A_MASKS-1:0]  tap_apar;
  logic [TAPS-1:0][PAIRS-1:0]    tap_match;
  logic [TAPS-1:0]               tap_vld;
  logic [TAPS-1:0]               tap_last;
  logic [TOTAL-1:0]              inc_vec;
  logic [TOTAL-1:0][CNT_W-1:0]   cnt_bus;
  logic                          done_q;
  logic                          shift_eff;
  logic                          run_finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= '0;
    else if (start_i) key_q <= key_i;
  end

  lmc_pt_gen #(.N_BITS(N_BITS)) u_pt_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .pt_o    (pt),
    .issue_o (issue),
    .last_o  (pt_last)
  );

  lmc_cipher_pipe #(
    .N_BITS      (N_BITS),
    .ROUNDS      (ROUNDS),
    .TAPS        (TAPS),
    .A_MASKS     (A_MASKS),
    .ALPHA_MASKS (ALPHA_MASKS)
  ) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (start_i),
    .key_i      (key_q),
    .pt_i       (pt),
    .issue_i    (issue),
    .last_i     (pt_last),
    .tap_data_o (tap_data),
    .tap_vld_o  (tap_pvld),
    .tap_last_o (tap_plast),
    .tap_apar_o (tap_apar)
  );

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    lmc_tap_mask #(
      .N_BITS     (N_BITS),
      .A_MASKS    (A_MASKS),
      .B_MASKS    (B_MASKS),
      .BETA_MASKS (BETA_MASKS)
    ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (start_i),
      .data_i  (tap_data[t]),
      .vld_i   (tap_pvld[t]),
      .last_i  (tap_plast[t]),
      .apar_i  (tap_apar[t]),
      .match_o (tap_match[t]),
      .vld_o   (tap_vld[t]),
      .last_o  (tap_last[t])
    );

    assign inc_vec[t*PAIRS +: PAIRS] = tap_match[t] & {PAIRS{tap_vld[t]}};

    // R5
    tap_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_vld[t] && tap_last[t]) |-> !done_q);
  end

  assign run_finished = tap_vld[TAPS-1] && tap_last[TAPS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_q <= 1'b0;
    else if (start_i)      done_q <= 1'b0;
    else if (run_finished) done_q <= 1'b1;
  end

  assign shift_eff = shift_i && done_q && !start_i;

  lmc_count_chain #(.CNT_W(CNT_W), .TOTAL(TOTAL)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .shift_i (shift_eff),
    .inc_i   (inc_vec),
    .chain_i (chain_in_i),
    .cnt_o   (cnt_bus),
    .chain_o (chain_out_o)
  );

  assign done_o = done_q;

  // R7
  shift_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !done_q && !start_i && inc_vec == '0) |=> $stable(cnt_bus));

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !shift_i && !start_i) |=> $stable(cnt_bus));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);

  // R5
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tap_vld == '0 && inc_vec == '0));

endmodule

// File: tb/lmc_corr_array_bench.sv
module lmc_corr_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB     = 8;
  localparam int RND    = 4;
  localparam int TP     = 2;
  localparam int NA     = 2;
  localparam int NBM    = 2;
  localparam int TOT    = TP * NA * NBM;
  localparam int TFIRST = RND - TP + 1;
  localparam int DONE_EDGE = (1 << NB) + RND + 2;
  localparam int WMASK  = (1 << NB) - 1;
  localparam int SB [16] = '{6, 11, 0, 9, 14, 3, 12, 5, 8, 15, 2, 13, 1, 4, 10, 7};
  localparam int AM [NA]  = '{'h00, 'h5A};
  localparam int BM [NBM] = '{'h00, 'hC3};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [NB-1:0] key;
  logic          shift;
  logic [NB:0]   chain_in;
  logic [NB:0]   chain_out;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int exp_cnt [TOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  lmc_corr_array #(
    .N_BITS(NB), .ROUNDS(RND), .TAPS(TP), .A_MASKS(NA), .B_MASKS(NBM),
    .ALPHA_MASKS(16'h5A00), .BETA_MASKS(16'hC300)
  ) u_lmc_corr_array (
    .clk(clk), .rst_n(rst_n), .start_i(start), .key_i(key), .shift_i(shift),
    .chain_in_i(chain_in), .chain_out_o(chain_out), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural reference of the cipher
  function automatic int b_sub(int v);
    int r = 0;
    for (int j = 0; j < NB / 4; j++) r |= SB[(v >> (4*j)) & 15] << (4*j);
    return r;
  endfunction

  function automatic int b_perm(int v);
    int r = 0;
    for (int i = 0; i < NB; i++) begin
      if (((v >> i) & 1) == 1) begin
        if (i == NB - 1) r |= 1 << i;
        else             r |= 1 << ((i * (NB / 4)) % (NB - 1));
      end
    end
    return r;
  endfunction

  function automatic int b_rk(int k, int r);
    return (((k << r) | (k >> (NB - r))) & WMASK) ^ r;
  endfunction

  function automatic int b_par(int v);
    int c = 0;
    for (int i = 0; i < NB; i++) c += (v >> i) & 1;
    return c % 2;
  endfunction

  task automatic model(input int k);
    for (int i = 0; i < TOT; i++) exp_cnt[i] = 0;
    for (int p = 0; p < (1 << NB); p++) begin
      int s = p ^ b_rk(k, 0);
      for (int r = 1; r <= RND; r++) begin
        s = b_perm(b_sub(s)) ^ b_rk(k, r);
        if (r >= TFIRST) begin
          for (int a = 0; a < NA; a++)
            for (int b = 0; b < NBM; b++)
              if (b_par(p & AM[a]) == b_par(s & BM[b]))
                exp_cnt[((r - TFIRST) * NA + a) * NBM + b]++;
        end
      end
    end
  endtask

  task automatic do_start(input int k);
    key   = k[NB-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // compare done against the expected cycle on every clock (R5, R7, R6)
  task automatic track_run(input bit with_shift);
    for (int cyc = 0; cyc <= DONE_EDGE + 1; cyc++) begin
      chk(done == (cyc >= DONE_EDGE), "R5 done timing", int'(done), int'(cyc >= DONE_EDGE));
      shift    = with_shift && (cyc == 20 || cyc == 21 || cyc == 150);
      chain_in = shift ? 9'h1AB : '0;
      @(negedge clk);
    end
    shift    = 1'b0;
    chain_in = '0;
  endtask

  task automatic readout(input int k, input string tag);
    int held;
    model(k);
    held = int'(chain_out);
    repeat (5) @(negedge clk);
    chk(int'(chain_out) == held, "R8 hold after done", int'(chain_out), held);
    for (int i = TOT - 1; i >= 0; i--) begin
      chk(int'(chain_out) == exp_cnt[i], {"R3 R4 count ", tag}, int'(chain_out), exp_cnt[i]);
      if (i == 0)
        chk(int'(chain_out) == (1 << NB), "R3 full count without wrap", int'(chain_out), 1 << NB);
      shift    = 1'b1;
      chain_in = (i == TOT - 1) ? 9'h155 : '0;
      @(negedge clk);
      shift    = 1'b0;
      chain_in = '0;
    end
    chk(int'(chain_out) == 'h155, "R4 chain input reaches output", int'(chain_out), 'h155);
  endtask

  task automatic finish_test;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_test();
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    key      = '0;
    shift    = 1'b0;
    chain_in = '0;
    repeat (3) @(negedge clk);
    // R9
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    chk(chain_out == '0, "R9 reset counter", int'(chain_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: shift before any run is ignored
    shift = 1'b1;
    chain_in = 9'h0F0;
    @(negedge clk);
    shift = 1'b0;
    chain_in = '0;
    chk(chain_out == '0, "R7 shift while idle ignored", int'(chain_out), 0);

    // R1 R2 R3: clean run
    do_start('h3C);
    track_run(1'b0);
    readout('h3C, "key 3C");

    // R6 R7: start clears leftovers; shift during run ignored
    do_start('hA7);
    track_run(1'b1);
    readout('hA7, "key A7 shifts mid-run");

    // R6: restart in mid-run
    do_start('h11);
    repeat (100) @(negedge clk);
    do_start('hE4);
    track_run(1'b0);
    readout('hE4, "key E4 after restart");

    finish_test();
  end

endmodule